// File: doc/BRIEF.md
# Programmable Edge/Level Trigger Unit

This block conditions 64 raw interrupt lines before they reach an enable and status stage. The lines are split into two banks of 32. Each line passes through a two-flop synchroniser. Two configuration bits then choose one of four trigger behaviours for that line: rising edge, falling edge, active-high level or active-low level.

In the two edge modes, a detected edge sets a sticky latch. The latch holds until software writes a one to that line's bit in the raw-event register. In the level modes, the output follows the synchronised input, inverted when the mode is active-low, and the latch is held clear. The 64-bit conditioned vector leaves the block on `trig_o`.

Software reaches each bank through a small register window. Bank 1 sits 0x20 above bank 0. Address bits [4:0] select the register and the bits above them select the bank.

Top module: `trig_cond_unit`

## Requirements
- R1: After reset, every configuration bit and every edge latch is zero. All lines are then in active-high level mode, so `trig_o` is 0 while the inputs are 0.
- R2: Within a bank, a write to offset 0x10 sets the rise-config bits where the data has ones, and a write to 0x14 clears them. A write to 0x18 sets fall-config bits and a write to 0x1C clears them. The rise and fall configuration read back at 0x08 and 0x0C. Writes to 0x08 and 0x0C have no effect.
- R3: With rise=0 and fall=0 (active-high level), the line's `trig_o` bit equals the input, two clock edges after the input changes.
- R4: With rise=1 and fall=1 (active-low level), the line's `trig_o` bit equals the inverted input, two clock edges after the input changes.
- R5: With rise=1 and fall=0 (rising edge), a 0-to-1 input transition sets the latch, and `trig_o` goes to 1 three clock edges after the input change. The latch stays set after the input returns low. A 1-to-0 transition does not set it.
- R6: With rise=0 and fall=1 (falling edge), a 1-to-0 transition sets the latch. A 0-to-1 transition does not set it.
- R7: A write to offset 0x04 clears the latches whose data bits are 1. Latches whose data bits are 0 are left unchanged.
- R8: If an edge is detected in the same cycle as an acknowledge of that line, the latch stays set.
- R9: Offset 0x00 reads the bank's 32 conditioned output bits, and offset 0x04 reads the bank's latch bits. Bit n of bank b is line 32*b+n.
- R10: The register set of bank 1 (lines 32 to 63) is identical to bank 0's, placed 0x20 higher.
- R11: A line in a level mode keeps its latch clear. An edge latched before the line is switched to a level mode is therefore gone when the line returns to an edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 64 | Raw interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address for the write and the read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| trig_o | output | 64 | Conditioned trigger vector |

## Verification
The latch properties assume that a write reaches a latch only through the acknowledge register. They also assume that the configuration of a line does not change in the same cycle as an edge on that line, except where the level-mode clearing property covers the change.

The stimulus keeps to these assumptions. It applies new configuration first and waits several cycles before it moves any input. It changes inputs only at the falling clock edge. It places the single deliberate acknowledge-versus-edge collision on the exact cycle in which the synchronised edge is seen.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_W = 5;
  localparam logic [REG_W-1:0] OFF_STAT    = 5'h00;
  localparam logic [REG_W-1:0] OFF_RAW     = 5'h04;
  localparam logic [REG_W-1:0] OFF_RISE    = 5'h08;
  localparam logic [REG_W-1:0] OFF_FALL    = 5'h0C;
  localparam logic [REG_W-1:0] OFF_RISE_S  = 5'h10;
  localparam logic [REG_W-1:0] OFF_RISE_C  = 5'h14;
  localparam logic [REG_W-1:0] OFF_FALL_S  = 5'h18;
  localparam logic [REG_W-1:0] OFF_FALL_C  = 5'h1C;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/trig_bank.sv
module trig_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] rise_set_i,
  input  logic [W-1:0] rise_clr_i,
  input  logic [W-1:0] fall_set_i,
  input  logic [W-1:0] fall_clr_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] rise_cfg_o,
  output logic [W-1:0] fall_cfg_o
);
  logic [W-1:0] sync_w, prev_q, rise_q, fall_q, latch_q;
  logic [W-1:0] rise_ev, fall_ev, edge_mode, hit;

  line_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_w)
  );

  assign rise_ev   = sync_w & ~prev_q;
  assign fall_ev   = ~sync_w & prev_q;
  assign edge_mode = rise_q ^ fall_q;
  assign hit       = (rise_q & ~fall_q & rise_ev) | (~rise_q & fall_q & fall_ev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_w;
      rise_q  <= (rise_q | rise_set_i) & ~rise_clr_i;
      fall_q  <= (fall_q | fall_set_i) & ~fall_clr_i;
      // new edge wins over a simultaneous acknowledge
      latch_q <= ((latch_q & ~ack_i) | hit) & edge_mode;
    end
  end

  // level modes: rise=fall=0 follows input, rise=fall=1 inverts it
  assign trig_o     = edge_mode ? latch_q : (sync_w ^ rise_q);
  assign latch_o    = latch_q;
  assign rise_cfg_o = rise_q;
  assign fall_cfg_o = fall_q;

  AST_LATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(latch_q) & ~$past(ack_i) & $past(edge_mode) & ~latch_q) == '0)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0) |=> ((latch_q & $past(ack_i) & ~$past(hit)) == '0)); // R7
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((latch_q & $past(hit)) == $past(hit))); // R8
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(edge_mode)) == '0)); // R11
  AST_RISE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_set_i != '0 && rise_clr_i == '0) |=> ((rise_q & $past(rise_set_i)) == $past(rise_set_i))); // R2
  AST_FALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_clr_i != '0) |=> ((fall_q & $past(fall_clr_i)) == '0)); // R2
endmodule

// File: rtl/trig_cond_unit.sv
module trig_cond_unit
  import trig_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int BANK_W = 32,
  localparam int NBANK  = LINES / BANK_W,
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int AW     = BSEL_W + REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  line_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic [LINES-1:0]  trig_o
);
  logic [REG_W-1:0]  reg_sel;
  logic [BSEL_W-1:0] bank_sel;
  logic [BANK_W-1:0] b_trig  [NBANK];
  logic [BANK_W-1:0] b_latch [NBANK];
  logic [BANK_W-1:0] b_rise  [NBANK];
  logic [BANK_W-1:0] b_fall  [NBANK];

  assign reg_sel  = addr_i[REG_W-1:0];
  assign bank_sel = addr_i[AW-1:REG_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_b;
    assign hit_b = wr_en_i && (bank_sel == BSEL_W'(b));

    trig_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (line_i[b*BANK_W +: BANK_W]),
      .rise_set_i((hit_b && reg_sel == OFF_RISE_S) ? wdata_i : '0),
      .rise_clr_i((hit_b && reg_sel == OFF_RISE_C) ? wdata_i : '0),
      .fall_set_i((hit_b && reg_sel == OFF_FALL_S) ? wdata_i : '0),
      .fall_clr_i((hit_b && reg_sel == OFF_FALL_C) ? wdata_i : '0),
      .ack_i     ((hit_b && reg_sel == OFF_RAW)    ? wdata_i : '0),
      .trig_o    (b_trig[b]),
      .latch_o   (b_latch[b]),
      .rise_cfg_o(b_rise[b]),
      .fall_cfg_o(b_fall[b])
    );
    assign trig_o[b*BANK_W +: BANK_W] = b_trig[b];
  end

  always_comb begin
    rdata_o = '0;
    if (int'(bank_sel) < NBANK) begin
      unique case (reg_sel)
        OFF_STAT: rdata_o = b_trig[bank_sel];
        OFF_RAW:  rdata_o = b_latch[bank_sel];
        OFF_RISE: rdata_o = b_rise[bank_sel];
        OFF_FALL: rdata_o = b_fall[bank_sel];
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (trig_o == '0)); // R1
endmodule

// File: tb/trig_cond_unit_test.sv
module trig_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] trig;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  trig_cond_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .trig_o(trig)
  );

  // {rise, fall, before, after, expected}
  localparam logic [4:0] VEC [8] = '{
    5'b00_01_1, 5'b00_10_0,   // R3
    5'b10_01_1, 5'b10_10_0,   // R5
    5'b01_10_1, 5'b01_01_0,   // R6
    5'b11_01_0, 5'b11_10_1    // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_all(input logic r, input logic f);
      for (int b = 0; b < 2; b++) begin
      wr(6'(b*32 + 'h14), '1);
      wr(6'(b*32 + 'h1C), '1);
      if (r) wr(6'(b*32 + 'h10), '1);
      if (f) wr(6'(b*32 + 'h18), '1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 trig", trig, '0);
    rd(6'h04, d); chk("R1 raw", 64'(d), '0);
    rd(6'h08, d); chk("R1 rise", 64'(d), '0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      cfg_all(VEC[i][4], VEC[i][3]);
      line = {64{VEC[i][2]}};
      cyc(4);
      wr(6'h04, '1); wr(6'h24, '1);
      line = {64{VEC[i][1]}};
      cyc(4);
      chk($sformatf("R3/R4/R5/R6 vec%0d", i), trig, {64{VEC[i][0]}});
    end

    // R2 config set/clear and readback, write to read-only ignored
    cfg_all(1'b0, 1'b0);
    line = '0;
    wr(6'h10, 32'hA5A5_A5A5);
    rd(6'h08, d); chk("R2 rise set", 64'(d), 64'hA5A5_A5A5);
    wr(6'h14, 32'h0000_FFFF);
    rd(6'h08, d); chk("R2 rise clr", 64'(d), 64'hA5A5_0000);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R2 ro ignored", 64'(d), 64'hA5A5_0000);
    // R10 high bank
    wr(6'h38, 32'h0F0F_0F0F);
    wr(6'h3C, 32'h0000_000F);
    rd(6'h2C, d); chk("R10 fall hi", 64'(d), 64'h0F0F_0F00);
    rd(6'h0C, d); chk("R10 fall lo untouched", 64'(d), 64'h0);

    // R7 partial acknowledge
    cfg_all(1'b1, 1'b0);
    line = '0; cyc(4);
    wr(6'h04, '1); wr(6'h24, '1);
    line = '1; cyc(4);
    wr(6'h04, 32'h0000_000F);
    rd(6'h04, d); chk("R7 lo partial", 64'(d), 64'hFFFF_FFF0);
    rd(6'h24, d); chk("R7 hi untouched", 64'(d), 64'hFFFF_FFFF);
    // R9 status readback
    rd(6'h00, d); chk("R9 status lo", 64'(d), 64'hFFFF_FFF0);
    rd(6'h20, d); chk("R9 status hi", 64'(d), 64'hFFFF_FFFF);
    chk("R9 trig", trig, 64'hFFFF_FFFF_FFFF_FFF0);

    // R8 edge in same cycle as acknowledge
    line = '0; cyc(4);
    wr(6'h04, '1);
    @(negedge clk); line = '1;
    @(posedge clk); @(negedge clk);
    @(posedge clk);
    wr(6'h04, '1);  // captured on the edge where the synced rise is seen
    rd(6'h04, d); chk("R8 edge wins", 64'(d), 64'hFFFF_FFFF);

    // R11 level mode drops latch
    wr(6'h34, '1);
    cyc(2);
    rd(6'h24, d); chk("R11 level latch clr", 64'(d), 64'h0);
    chk("R11 level follows", trig[63:32], 64'hFFFF_FFFF);
    wr(6'h30, '1);
    cyc(2);
    chk("R11 edge no stale", trig[63:32], 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule